// File: doc/BRIEF.md
# Conditional Branch-to-Register Resolver

This block resolves a conditional branch whose destination comes from a target register. One operation arrives as a single-cycle valid pulse together with its operands: the loop counter, the current instruction address, the 32-bit condition register, the target register, the four decision bits of the branch-options field, the condition-bit selector, a link request and a 64-bit mode flag. The counter and the target arrive on separate operand ports, so both can be presented in the same cycle.

The block optionally decrements the counter and then tests it. The counter test uses either the full width or only the low half, depending on the mode flag. The block also compares one condition-register bit with the value that the options field expects. From these two tests it decides whether the branch is taken. It then produces the next instruction address, the counter write-back, and the link-register write-back. All results are registered and appear one cycle after the valid input, with write enables that the surrounding register-file logic consumes.

Bit numbering follows the most-significant-first convention. Bit 0 of a field is its leftmost bit. On the `opt_in` port, option bit k sits at `opt_in[3-k]`. Condition bit n sits at `cr_in[31-n]`.

Top module: `br_resolve`

## Requirements
- R1: While reset is high and on the first edge after it, `res_valid`, `ctr_we`, `lr_we` and `taken` are all 0.
- R2: `res_valid` equals the value `op_valid` had at the previous clock edge.
- R3: When option bit 2 (`opt_in[1]`) is 0, `ctr_we` is 1 and `ctr_out` is the input counter minus one, wrapping modulo 2^64. When option bit 2 is 1, `ctr_we` is 0.
- R4: The counter test passes when option bit 2 is 1. Otherwise it passes when (the tested bits of the decremented counter are nonzero) XOR option bit 3 (`opt_in[0]`) is 1.
- R5: When `mode64_in` is 1, all 64 bits of the decremented counter are tested. When it is 0, only bits 31..0 (LSB numbering) are tested.
- R6: The condition test passes when option bit 0 (`opt_in[3]`) is 1. Otherwise it passes when `cr_in[31-crsel_in]` equals option bit 1 (`opt_in[2]`).
- R7: `taken` is 1 exactly when both the counter test and the condition test pass.
- R8: When taken, `nia_out` equals `tar_in` with its two least significant bits cleared.
- R9: When not taken, `nia_out` equals `cia_in + 4`.
- R10: When `link_in` is 1, `lr_we` is 1 and `lr_out` equals `cia_in + 4`, whether or not the branch is taken. When `link_in` is 0, `lr_we` is 0.
- R11: In a cycle that follows a cycle without `op_valid`, `ctr_we` and `lr_we` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| ctr_in | input | 64 | Counter operand |
| cia_in | input | 64 | Current instruction address |
| cr_in | input | 32 | Condition register |
| tar_in | input | 64 | Target register operand |
| opt_in | input | 4 | Branch option bits 0..3, bit 0 at `opt_in[3]` |
| crsel_in | input | 5 | Condition bit selector |
| link_in | input | 1 | Request link-register write |
| mode64_in | input | 1 | 1: test 64 counter bits, 0: test low 32 |
| res_valid | output | 1 | Results valid |
| ctr_out | output | 64 | Counter write-back value |
| ctr_we | output | 1 | Counter write enable |
| taken | output | 1 | Branch taken |
| nia_out | output | 64 | Next instruction address |
| lr_out | output | 64 | Link-register write-back value |
| lr_we | output | 1 | Link-register write enable |

## Verification
The counter write-back and the link write-back are independent side effects, and they can fall in the same result cycle as a taken branch. The bench sweeps every combination of the four option bits, the link flag and the mode flag against several counter and selector values. Many vectors therefore decrement the counter, write the link register and redirect fetch all at once. Each output is judged separately against values computed arithmetically in the bench. One counter value leaves the low half zero and the upper half nonzero after the decrement, which separates the two counter-test widths.

// File: rtl/br_resolve_pkg.sv
package br_resolve_pkg;
    localparam int XLEN      = 64;
    localparam int HALF      = XLEN / 2;
    localparam int CRW       = 32;
    localparam int SELW      = $clog2(CRW);
    localparam int OPTW      = 4;
    localparam int INSN_B    = 4;
    localparam int ALIGN_LSB = 2;

    // option bit positions, MSB-first numbering
    localparam int OPT_COND_IGN = 0;
    localparam int OPT_COND_VAL = 1;
    localparam int OPT_CTR_KEEP = 2;
    localparam int OPT_CTR_ZERO = 3;

    typedef struct packed {
        logic [XLEN-1:0] ctr;
        logic [XLEN-1:0] cia;
        logic [XLEN-1:0] tar;
        logic [CRW-1:0]  cr;
        logic [OPTW-1:0] opt;
        logic [SELW-1:0] sel;
        logic            link;
        logic            mode64;
    } br_op_t;

    typedef struct packed {
        logic [XLEN-1:0] ctr;
        logic            ctr_we;
        logic            taken;
        logic [XLEN-1:0] nia;
        logic [XLEN-1:0] lr;
        logic            lr_we;
    } br_res_t;

    function automatic logic opt_bit(input logic [OPTW-1:0] opt, input int idx);
        return opt[OPTW-1-idx];
    endfunction
endpackage

// File: rtl/br_ctr_unit.sv
module br_ctr_unit #(
    parameter int XLEN = 64,
    parameter int HALF = 32
) (
    input  logic [XLEN-1:0] ctr,
    input  logic            keep,
    input  logic            want_zero,
    input  logic            mode64,
    output logic [XLEN-1:0] ctr_nxt,
    output logic            ctr_ok
);
    logic [XLEN-1:0] dec;
    logic            nz;

    assign dec     = ctr - XLEN'(1);
    assign ctr_nxt = keep ? ctr : dec;

    generate
        if (HALF < XLEN) begin : g_split
            assign nz = mode64 ? (|dec) : (|dec[HALF-1:0]);
        end else begin : g_full
            logic unused_mode;
            assign unused_mode = mode64;
            assign nz = |dec;
        end
    endgenerate

    assign ctr_ok = keep | (nz ^ want_zero);
endmodule

// File: rtl/br_cond_unit.sv
module br_cond_unit #(
    parameter int CRW  = 32,
    parameter int SELW = 5
) (
    input  logic [CRW-1:0]  cr,
    input  logic [SELW-1:0] sel,
    input  logic            ignore,
    input  logic            expect_val,
    output logic            cond_ok
);
    localparam logic [SELW-1:0] TOP = SELW'(CRW - 1);
    logic [SELW-1:0] idx;
    logic            bit_val;

    assign idx     = TOP - sel;
    assign bit_val = cr[idx];
    assign cond_ok = ignore | (bit_val == expect_val);
endmodule

// File: rtl/br_next_addr.sv
module br_next_addr #(
    parameter int XLEN   = 64,
    parameter int INSN_B = 4,
    parameter int ALIGN  = 2
) (
    input  logic [XLEN-1:0] cia,
    input  logic [XLEN-1:0] tar,
    input  logic            taken,
    output logic [XLEN-1:0] nia,
    output logic [XLEN-1:0] seq
);
    localparam logic [XLEN-1:0] MASK = ~XLEN'((1 << ALIGN) - 1);

    assign seq = cia + XLEN'(INSN_B);
    assign nia = taken ? (tar & MASK) : seq;
endmodule

// File: rtl/br_resolve.sv
module br_resolve
    import br_resolve_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [63:0]     ctr_in,
    input  logic [63:0]     cia_in,
    input  logic [31:0]     cr_in,
    input  logic [63:0]     tar_in,
    input  logic [3:0]      opt_in,
    input  logic [4:0]      crsel_in,
    input  logic            link_in,
    input  logic            mode64_in,
    output logic            res_valid,
    output logic [63:0]     ctr_out,
    output logic            ctr_we,
    output logic            taken,
    output logic [63:0]     nia_out,
    output logic [63:0]     lr_out,
    output logic            lr_we
);
    br_op_t  op;
    br_res_t res_d, res_q;
    logic    valid_q;
    logic    ctr_ok, cond_ok, take;
    logic [XLEN-1:0] ctr_nxt, nia, seq;

    always_comb begin
        op.ctr    = ctr_in;
        op.cia    = cia_in;
        op.tar    = tar_in;
        op.cr     = cr_in;
        op.opt    = opt_in;
        op.sel    = crsel_in;
        op.link   = link_in;
        op.mode64 = mode64_in;
    end

    br_ctr_unit #(.XLEN(XLEN), .HALF(HALF)) u_ctr (
        .ctr       (op.ctr),
        .keep      (opt_bit(op.opt, OPT_CTR_KEEP)),
        .want_zero (opt_bit(op.opt, OPT_CTR_ZERO)),
        .mode64    (op.mode64),
        .ctr_nxt   (ctr_nxt),
        .ctr_ok    (ctr_ok)
    );

    br_cond_unit #(.CRW(CRW), .SELW(SELW)) u_cond (
        .cr         (op.cr),
        .sel        (op.sel),
        .ignore     (opt_bit(op.opt, OPT_COND_IGN)),
        .expect_val (opt_bit(op.opt, OPT_COND_VAL)),
        .cond_ok    (cond_ok)
    );

    assign take = ctr_ok & cond_ok;

    br_next_addr #(.XLEN(XLEN), .INSN_B(INSN_B), .ALIGN(ALIGN_LSB)) u_nia (
        .cia   (op.cia),
        .tar   (op.tar),
        .taken (take),
        .nia   (nia),
        .seq   (seq)
    );

    always_comb begin
        res_d.ctr    = ctr_nxt;
        res_d.ctr_we = op_valid & ~opt_bit(op.opt, OPT_CTR_KEEP);
        res_d.taken  = op_valid & take;
        res_d.nia    = nia;
        res_d.lr     = seq;
        res_d.lr_we  = op_valid & op.link;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q      <= op_valid;
            res_q.ctr_we <= res_d.ctr_we;
            res_q.taken  <= res_d.taken;
            res_q.lr_we  <= res_d.lr_we;
            if (op_valid) begin
                res_q.ctr <= res_d.ctr;
                res_q.nia <= res_d.nia;
                res_q.lr  <= res_d.lr;
            end
        end
    end

    assign res_valid = valid_q;
    assign ctr_out   = res_q.ctr;
    assign ctr_we    = res_q.ctr_we;
    assign taken     = res_q.taken;
    assign nia_out   = res_q.nia;
    assign lr_out    = res_q.lr;
    assign lr_we     = res_q.lr_we;

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid);
    // R3
    ctr_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !opt_in[1]) |=> (ctr_we && ctr_out == $past(ctr_in) - 64'd1));
    // R3
    ctr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opt_in[1]) |=> !ctr_we);
    // R7
    always_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && opt_in[3] && opt_in[1]) |=> taken);
    // R8
    target_align_chk: assert property (@(posedge clk) disable iff (rst)
        taken |-> (nia_out[1:0] == 2'b00));
    // R10
    link_value_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && link_in) |=> (lr_we && lr_out == $past(cia_in) + 64'd4));
    // R11
    we_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (ctr_we || lr_we) |-> res_valid);
endmodule

// File: tb/tb_br_resolve.sv
module tb_br_resolve;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [63:0] ctr_in, cia_in, tar_in;
    logic [31:0] cr_in;
    logic [3:0]  opt_in;
    logic [4:0]  crsel_in;
    logic        link_in, mode64_in;
    logic        res_valid, ctr_we, taken, lr_we;
    logic [63:0] ctr_out, nia_out, lr_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolve dut (
        .clk(clk), .rst(rst), .op_valid(op_valid),
        .ctr_in(ctr_in), .cia_in(cia_in), .cr_in(cr_in), .tar_in(tar_in),
        .opt_in(opt_in), .crsel_in(crsel_in), .link_in(link_in),
        .mode64_in(mode64_in), .res_valid(res_valid), .ctr_out(ctr_out),
        .ctr_we(ctr_we), .taken(taken), .nia_out(nia_out), .lr_out(lr_out),
        .lr_we(lr_we)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ctr_val(input int k);
        case (k)
            0: return 64'd0;
            1: return 64'd1;
            2: return 64'd7;
            default: return 64'h0000_0001_0000_0001;
        endcase
    endfunction

    function automatic logic [4:0] sel_val(input int k);
        case (k)
            0: return 5'd0;
            1: return 5'd7;
            2: return 5'd19;
            default: return 5'd31;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%h expected=%h", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0;
        ctr_in = '0; cia_in = '0; tar_in = '0; cr_in = '0;
        opt_in = '0; crsel_in = '0; link_in = 1'b0; mode64_in = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!res_valid && !ctr_we && !lr_we && !taken, "R1",
              {60'd0, res_valid, ctr_we, lr_we, taken}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!res_valid && !ctr_we && !lr_we && !taken, "R1 after",
              {60'd0, res_valid, ctr_we, lr_we, taken}, 64'd0);

        for (int o = 0; o < 16; o++)
        for (int s = 0; s < 4; s++)
        for (int c = 0; c < 4; c++)
        for (int m = 0; m < 2; m++)
        for (int l = 0; l < 2; l++) begin
            logic [63:0] dec, e_nia, e_lr, cia, tar;
            logic [31:0] cr;
            logic b0, b1, b2, b3, nz, c_ok, k_ok, e_take, crbit;
            cia = 64'h0000_7FFF_FFFF_FFF0 + 64'(o * 64 + c * 8);
            tar = 64'hCAFE_0000_1234_5677 ^ 64'(s * 16);
            cr  = (o % 2 == 0) ? 32'hA5C3_0F96 : 32'h5A3C_F069;
            op_valid  = 1'b1;
            ctr_in    = ctr_val(c);
            cia_in    = cia;
            tar_in    = tar;
            cr_in     = cr;
            opt_in    = 4'(o);
            crsel_in  = sel_val(s);
            link_in   = 1'(l);
            mode64_in = 1'(m);
            b0 = opt_in[3]; b1 = opt_in[2]; b2 = opt_in[1]; b3 = opt_in[0];
            dec   = ctr_in - 64'd1;
            nz    = (m == 1) ? (dec != 0) : (dec[31:0] != 0);
            k_ok  = b2 | (nz ^ b3);
            crbit = cr[31 - sel_val(s)];
            c_ok  = b0 | (crbit == b1);
            e_take = k_ok & c_ok;
            e_lr  = cia + 64'd4;
            e_nia = e_take ? {tar[63:2], 2'b00} : e_lr;
            @(negedge clk);
            check(res_valid == 1'b1, "R2", {63'd0, res_valid}, 64'd1);
            check(ctr_we == !b2, "R3 we", {63'd0, ctr_we}, {63'd0, !b2});
            if (!b2) check(ctr_out == dec, "R3 value", ctr_out, dec);
            // R4 R5 R6 R7: decision
            check(taken == e_take, (c == 3) ? "R5 R7" : "R4 R6 R7",
                  {63'd0, taken}, {63'd0, e_take});
            if (e_take) check(nia_out == e_nia, "R8", nia_out, e_nia);
            else        check(nia_out == e_nia, "R9", nia_out, e_nia);
            check(lr_we == 1'(l), "R10 we", {63'd0, lr_we}, 64'(l));
            if (l == 1) check(lr_out == e_lr, "R10 value", lr_out, e_lr);
        end

        // R11: idle cycle after activity with link and decrement requested
        op_valid = 1'b1; opt_in = 4'b0000; link_in = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        @(negedge clk);
        check(!res_valid, "R11 valid", {63'd0, res_valid}, 64'd0);
        check(!ctr_we && !lr_we, "R11 enables", {62'd0, ctr_we, lr_we}, 64'd0);
        check(!taken, "R11 taken", {63'd0, taken}, 64'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule